// File: doc/BRIEF.md
# Peripheral Firmware Bank Mapper

This block sits on a peripheral expansion card of an 8-bit system bus and steers every firmware access to one of two 2K x 8 memories: a read-only half and a writable RAM half. The card sees three bus strobes, all active low. The slot strobe covers the card's 256-byte slot firmware page. The expansion strobe covers the shared 2 KB expansion window. The device strobe covers the card's sixteen I/O soft-switch addresses. The block turns the address, the read/write-low line and these strobes into chip, output and write enables for both memories, plus an 11-bit memory offset.

A one-bit bank register changes as a side effect of bus accesses, with no data write involved. Any slot-page access returns it to bank 1. A device-strobe access with address bit 0 high moves it to bank 2. The bank drives the memories' twelfth address line. In split mode (`SPLIT_MODE=1`) that line acts as a device select: bank 1 reaches the read-only half and bank 2 reaches the RAM half. In banked mode (`SPLIT_MODE=0`) a single 4 KB read-only device takes the bank as its address bit 11, and the RAM is never enabled.

Top module: `fwbank_mapper`

## Requirements
- R1: After reset, `bank_o` is 0. Encoding: 0 means bank 1, 1 means bank 2.
- R2: On a cycle with `slot_sel_n` low, the access already uses bank 1. `bank_o` is 0 from the next cycle on.
- R3: On a cycle with `dev_sel_n` low, `slot_sel_n` high and `addr[0]`=1, `bank_o` becomes 1 on the next cycle. With `addr[0]`=0 the bank is unchanged.
- R4: With `slot_sel_n` and `exp_sel_n` both high, `rom_ce_n`, `rom_oe_n`, `ram_ce_n`, `ram_oe_n` and `ram_we_n` are all 1. With `dev_sel_n` also high, `bank_o` holds its value.
- R5: `mem_off` equals `{3'b000, addr[7:0]}` on a slot access and `addr[10:0]` on an expansion access. As a result, slot offsets 0x00-0xFF reach the same bytes as expansion addresses 0xC800-0xC8FF.
- R6: In split mode, a firmware access in bank 1 enables only the read-only half, and one in bank 2 enables only `ram_ce_n`. The two chip enables are never low together, and `rom_a11` is 0.
- R7: During a RAM access, `ram_we_n` equals `rw_n` and `ram_oe_n` equals the inverse of `rw_n`.
- R8: The read-only half ignores writes. `rom_ce_n` and `rom_oe_n` stay 1 when `rw_n`=0, and `rom_we_n` is always 1.
- R9: In banked mode, every firmware read enables the read-only device with `rom_a11` equal to the effective bank, and `ram_ce_n` stays 1.
- R10: A byte written to the RAM half in bank 2 reads back unchanged at the same expansion address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| rw_n | input | 1 | 1 = read, 0 = write |
| slot_sel_n | input | 1 | Slot firmware page strobe, active low |
| exp_sel_n | input | 1 | Expansion window strobe, active low |
| dev_sel_n | input | 1 | Soft-switch strobe, active low |
| mem_off | output | 11 | Offset into the selected 2K half |
| rom_a11 | output | 1 | Address bit 11 of the read-only device |
| rom_ce_n | output | 1 | Read-only chip enable, active low |
| rom_oe_n | output | 1 | Read-only output enable, active low |
| rom_we_n | output | 1 | Read-only write enable, tied inactive |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| bank_o | output | 1 | Current bank register value |

## Verification
The RAM half is hard to reach. Any slot-page access forces bank 1, so RAM can only be reached through the expansion strobe, and only after a device-strobe access with an odd address and before any later slot access. The stimulus therefore plays explicit sequences: an odd soft-switch hit, expansion writes and reads, then a slot access that must snap the bank back. It also plays an even soft-switch hit, which must leave the bank alone. Both mode variants receive the same bus traffic, and a behavioural model predicts their enables and read data on every cycle.

// File: rtl/fwbm_pkg.sv
package fwbm_pkg;
  typedef enum logic {
    BANK_ONE = 1'b0,
    BANK_TWO = 1'b1
  } bank_e;

  typedef struct packed {
    logic rom_sel;
    logic ram_sel;
  } route_t;

  // Half selection from the effective bank; split mode uses the bank as device select.
  function automatic route_t pick_half(input logic hit, input bank_e bank, input logic split);
    route_t r;
    r.rom_sel = hit & (~split | (bank == BANK_ONE));
    r.ram_sel = hit & split & (bank == BANK_TWO);
    return r;
  endfunction
endpackage

// File: rtl/fwbm_decode.sv
module fwbm_decode #(
  parameter int ADDR_W  = 16,
  parameter int HALF_AW = 11,
  parameter int SLOT_AW = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               slot_sel_n,
  input  logic               exp_sel_n,
  input  logic               dev_sel_n,
  output logic               slot_hit,
  output logic               fw_hit,
  output logic               dev_odd_hit,
  output logic [HALF_AW-1:0] off
);
  localparam int PAD_W = HALF_AW - SLOT_AW;

  function automatic logic [HALF_AW-1:0] slot_offset(input logic [ADDR_W-1:0] a);
    return {{PAD_W{1'b0}}, a[SLOT_AW-1:0]};
  endfunction

  function automatic logic [HALF_AW-1:0] exp_offset(input logic [ADDR_W-1:0] a);
    return a[HALF_AW-1:0];
  endfunction

  always_comb begin
    slot_hit    = ~slot_sel_n;
    fw_hit      = ~slot_sel_n | ~exp_sel_n;
    dev_odd_hit = ~dev_sel_n & slot_sel_n & addr[0];
    off         = slot_hit ? slot_offset(addr) : exp_offset(addr);
  end
endmodule

// File: rtl/fwbm_bank_reg.sv
module fwbm_bank_reg
  import fwbm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slot_hit,
  input  logic  dev_odd_hit,
  output bank_e bank_q,
  output bank_e bank_eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bank_q <= BANK_ONE;
    else if (slot_hit)    bank_q <= BANK_ONE;
    else if (dev_odd_hit) bank_q <= BANK_TWO;
  end

  // A slot access sees bank 1 within the same cycle.
  assign bank_eff = slot_hit ? BANK_ONE : bank_q;
endmodule

// File: rtl/fwbm_enable_gen.sv
module fwbm_enable_gen
  import fwbm_pkg::*;
#(
  parameter bit SPLIT_MODE = 1'b1
) (
  input  logic  fw_hit,
  input  bank_e bank_eff,
  input  logic  rw_n,
  output logic  rom_a11,
  output logic  rom_ce_n,
  output logic  rom_oe_n,
  output logic  rom_we_n,
  output logic  ram_ce_n,
  output logic  ram_oe_n,
  output logic  ram_we_n
);
  route_t rt;

  always_comb begin
    rt       = pick_half(fw_hit, bank_eff, SPLIT_MODE);
    rom_ce_n = ~(rt.rom_sel & rw_n);
    rom_oe_n = ~(rt.rom_sel & rw_n);
    rom_we_n = 1'b1;
    ram_ce_n = ~rt.ram_sel;
    ram_we_n = rt.ram_sel ? rw_n : 1'b1;
    ram_oe_n = rt.ram_sel ? ~rw_n : 1'b1;
  end

  generate
    if (SPLIT_MODE) begin : g_split
      assign rom_a11 = 1'b0;
    end else begin : g_banked
      assign rom_a11 = bank_eff;
    end
  endgenerate
endmodule

// File: rtl/fwbank_mapper.sv
module fwbank_mapper
  import fwbm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int HALF_AW    = 11,
  parameter int SLOT_AW    = 8,
  parameter bit SPLIT_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rw_n,
  input  logic               slot_sel_n,
  input  logic               exp_sel_n,
  input  logic               dev_sel_n,
  output logic [HALF_AW-1:0] mem_off,
  output logic               rom_a11,
  output logic               rom_ce_n,
  output logic               rom_oe_n,
  output logic               rom_we_n,
  output logic               ram_ce_n,
  output logic               ram_oe_n,
  output logic               ram_we_n,
  output logic               bank_o
);
  logic  slot_hit;
  logic  fw_hit;
  logic  dev_odd_hit;
  bank_e bank_q;
  bank_e bank_eff;

  fwbm_decode #(
    .ADDR_W (ADDR_W),
    .HALF_AW(HALF_AW),
    .SLOT_AW(SLOT_AW)
  ) u_dec (
    .addr       (addr),
    .slot_sel_n (slot_sel_n),
    .exp_sel_n  (exp_sel_n),
    .dev_sel_n  (dev_sel_n),
    .slot_hit   (slot_hit),
    .fw_hit     (fw_hit),
    .dev_odd_hit(dev_odd_hit),
    .off        (mem_off)
  );

  fwbm_bank_reg u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_hit   (slot_hit),
    .dev_odd_hit(dev_odd_hit),
    .bank_q     (bank_q),
    .bank_eff   (bank_eff)
  );

  fwbm_enable_gen #(
    .SPLIT_MODE(SPLIT_MODE)
  ) u_en (
    .fw_hit  (fw_hit),
    .bank_eff(bank_eff),
    .rw_n    (rw_n),
    .rom_a11 (rom_a11),
    .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n),
    .rom_we_n(rom_we_n),
    .ram_ce_n(ram_ce_n),
    .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n)
  );

  assign bank_o = bank_q;
endmodule

// File: rtl/fwbm_checker.sv
module fwbm_checker (
  input logic clk,
  input logic rst_n,
  input logic addr0,
  input logic rw_n,
  input logic slot_sel_n,
  input logic exp_sel_n,
  input logic dev_sel_n,
  input logic rom_ce_n,
  input logic rom_oe_n,
  input logic ram_ce_n,
  input logic ram_oe_n,
  input logic ram_we_n,
  input logic bank_o
);
  assert_slot_to_bank1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_sel_n |=> !bank_o);

  assert_odd_dev_to_bank2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_sel_n && slot_sel_n && addr0) |=> bank_o);

  assert_idle_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sel_n && dev_sel_n) |=> $stable(bank_o));

  assert_idle_no_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sel_n && exp_sel_n) |-> (rom_ce_n && rom_oe_n && ram_ce_n && ram_oe_n && ram_we_n));

  assert_halves_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(~rom_ce_n && ~ram_ce_n));

  assert_ram_write_only_on_bus_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ce_n && !rw_n && ram_oe_n));

  assert_rom_blind_to_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> (rom_ce_n && rom_oe_n));
endmodule

bind fwbank_mapper fwbm_checker u_fwbm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr0     (addr[0]),
  .rw_n      (rw_n),
  .slot_sel_n(slot_sel_n),
  .exp_sel_n (exp_sel_n),
  .dev_sel_n (dev_sel_n),
  .rom_ce_n  (rom_ce_n),
  .rom_oe_n  (rom_oe_n),
  .ram_ce_n  (ram_ce_n),
  .ram_oe_n  (ram_oe_n),
  .ram_we_n  (ram_we_n),
  .bank_o    (bank_o)
);

// File: tb/fwbank_mapper_tb_top.sv
`timescale 1ns/100ps
module fwbank_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rw_n = 1'b1;
  logic        slot_sel_n = 1'b1;
  logic        exp_sel_n = 1'b1;
  logic        dev_sel_n = 1'b1;
  logic [7:0]  wdata = 8'h00;

  logic [10:0] s_off, b_off;
  logic s_a11, s_rce, s_roe, s_rwe, s_mce, s_moe, s_mwe, s_bank;
  logic b_a11, b_rce, b_roe, b_rwe, b_mce, b_moe, b_mwe, b_bank;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  fwbank_mapper #(.SPLIT_MODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw_n(rw_n),
    .slot_sel_n(slot_sel_n), .exp_sel_n(exp_sel_n), .dev_sel_n(dev_sel_n),
    .mem_off(s_off), .rom_a11(s_a11), .rom_ce_n(s_rce), .rom_oe_n(s_roe),
    .rom_we_n(s_rwe), .ram_ce_n(s_mce), .ram_oe_n(s_moe), .ram_we_n(s_mwe),
    .bank_o(s_bank));

  fwbank_mapper #(.SPLIT_MODE(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw_n(rw_n),
    .slot_sel_n(slot_sel_n), .exp_sel_n(exp_sel_n), .dev_sel_n(dev_sel_n),
    .mem_off(b_off), .rom_a11(b_a11), .rom_ce_n(b_rce), .rom_oe_n(b_roe),
    .rom_we_n(b_rwe), .ram_ce_n(b_mce), .ram_oe_n(b_moe), .ram_we_n(b_mwe),
    .bank_o(b_bank));

  // Synchronous memories attached to the split-mode instance.
  logic [7:0] ram_arr [0:2047];
  logic [7:0] rd_q;

  function automatic logic [7:0] rom_byte(input int a12);
    return 8'((a12 * 7 + 8'h3C) ^ (a12 >> 4));
  endfunction

  always @(posedge clk) begin
    if (!s_mce && !s_mwe) ram_arr[s_off] <= wdata;
    if (!s_mce && !s_moe) rd_q <= ram_arr[s_off];
    else if (!s_rce && !s_roe) rd_q <= rom_byte({20'd0, s_a11, s_off});
  end

  // Behavioural reference state.
  int mbank = 0;
  int mram [int];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One bus cycle: drive at falling edge, check combinational outputs, update model at rising edge.
  task automatic bus(input logic [15:0] a, input bit rd, input bit slot, input bit expn,
                     input bit dev, input logic [7:0] wd);
    int off, eff, hit, rsel, msel;
    bit expect_rd;
    int exp_byte;
    @(negedge clk);
    addr = a; rw_n = rd; slot_sel_n = ~slot; exp_sel_n = ~expn; dev_sel_n = ~dev; wdata = wd;
    #1;
    hit  = (slot || expn) ? 1 : 0;
    eff  = slot ? 0 : mbank;
    off  = slot ? (a % 256) : (a % 2048);
    rsel = hit && eff == 0;
    msel = hit && eff == 1;
    chk("R3", "split bank_o", s_bank, mbank);
    chk("R3", "banked bank_o", b_bank, mbank);
    if (hit) begin
      chk("R5", "split mem_off", s_off, off);
      chk("R5", "banked mem_off", b_off, off);
    end
    chk("R6", "split rom_ce_n", s_rce, !(rsel && rd));
    chk("R6", "split ram_ce_n", s_mce, !msel);
    chk("R6", "split rom_a11", s_a11, 0);
    chk("R7", "split ram_we_n", s_mwe, msel ? rd : 1);
    chk("R7", "split ram_oe_n", s_moe, msel ? !rd : 1);
    chk("R8", "split rom_oe_n", s_roe, !(rsel && rd));
    chk("R8", "rom_we_n", s_rwe & b_rwe, 1);
    chk("R9", "banked rom_ce_n", b_rce, !(hit && rd));
    chk("R9", "banked ram_ce_n", b_mce, 1);
    chk("R9", "banked ram_we_n", b_mwe, 1);
    if (hit && rd) chk("R9", "banked rom_a11", b_a11, eff);
    if (!hit) chk("R4", "idle enables", {s_rce, s_roe, s_mce, s_moe, s_mwe}, 5'h1F);
    expect_rd = hit && rd;
    exp_byte = msel ? (mram.exists(off) ? mram[off] : -1) : rom_byte(off);
    @(posedge clk);
    if (msel && !rd) mram[off] = wd;
    if (slot) mbank = 0;
    else if (dev && a[0]) mbank = 1;
    #1;
    if (expect_rd && exp_byte >= 0) chk("R10", "read data", rd_q, exp_byte);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bus(16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "bank in reset", s_bank, 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1", "bank after reset", s_bank | b_bank, 0);
    idle(2);
    // ROM reads through slot page and expansion alias (R5).
    bus(16'hC105, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    bus(16'hC805, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    bus(16'hC9A0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    // Write to ROM region is ignored (R8).
    bus(16'hC9A0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77);
    // Even soft-switch leaves bank alone (R3).
    bus(16'hC0F2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    idle(1);
    chk("R3", "even switch no change", s_bank, 0);
    // Odd soft-switch selects bank 2 (R3), then RAM traffic (R6, R7, R10).
    bus(16'hC0F1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R3", "odd switch to bank2", s_bank, 1);
    for (int i = 0; i < 24; i++)
      bus(16'hC900 + 16'(i * 37), 1'b0, 1'b0, 1'b1, 1'b0, 8'(i * 11 + 3));
    for (int i = 0; i < 24; i++)
      bus(16'hC900 + 16'(i * 37), 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    bus(16'hCFFF, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5);
    bus(16'hCFFF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(3);
    chk("R4", "bank held while idle", s_bank, 1);
    // Slot access forces bank 1 in the same cycle (R2).
    bus(16'hC3FE, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R2", "bank1 after slot access", s_bank, 0);
    bus(16'hC0F3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    bus(16'hC2FF, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A);
    chk("R2", "slot write also forces bank1", s_bank, 0);
    // Mixed patterns across both modes.
    for (int i = 0; i < 200; i++) begin
      logic [15:0] a;
      a = 16'hC800 + 16'((i * 53) % 2048);
      case (i % 5)
        0: bus(16'hC0F1 + 16'((i % 4) * 2), 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        1: bus(a, 1'b0, 1'b0, 1'b1, 1'b0, 8'(i));
        2: bus(a, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        3: bus(16'hC100 + 16'(i % 256), 1'b1, (i % 3) == 0, 1'b0, 1'b0, 8'h00);
        default: bus(16'hC0F0, 1'b1, 1'b0, 1'b0, (i % 2) == 0, 8'h00);
      endcase
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule